// File: doc/BRIEF.md
# Host Data Width Packing Engine

This block sits between a narrow external host data path and a wider internal transaction path. The host side carries 8 or 16 bits per access, and the internal side carries words of 16 or 24 bits. On writes the block gathers successive host data accesses into one internal word and presents that word with a single-cycle valid pulse once every byte of it has arrived. On reads it requests one internal word at the start of a transaction, holds that word, and returns it piece by piece over the following accesses.

A small counter tracks the position of each access inside the current transaction. The number of accesses per transaction depends on the bus width and the data type, and an 8-bit bus carrying 24-bit data can optionally add a fourth, padding access. A byte-order setting chooses whether the least or the most significant part of the word moves first. Address generation and internal arbitration belong to other blocks.

Top module: `host_width_packer`

## Requirements
- R1: One transaction takes this many accesses: 8-bit bus with 16-bit data, 2; 8-bit bus with 24-bit data, 3, or 4 when `cfg_pad` is 1; 16-bit bus with 16-bit data, 1; 16-bit bus with 24-bit data, 2. `int_wvalid` stays 0 after every write access except the last one of a transaction.
- R2: With `cfg_big_end` = 0 on an 8-bit bus (`cfg_bus16` = 0), write access k carries word byte k (bits 8k+7:8k) on `acc_wdata[7:0]`, and `acc_wdata[15:8]` is ignored. On a 16-bit bus with 16-bit data, the single access carries the whole word, with `acc_wdata[7:0]` as byte 0.
- R3: With `cfg_big_end` = 1 the order of accesses is reversed. On an 8-bit bus, access k carries byte N-1-k, where N is 2 for 16-bit data and 3 for 24-bit data. On a 16-bit bus with 24-bit data, access 0 carries byte 2 and access 1 carries bytes 1:0.
- R4: On a 16-bit bus with 24-bit data, the access that carries only byte 2 uses `acc_wdata[7:0]` and ignores `acc_wdata[15:8]` on writes. On reads it returns byte 2 in `acc_rdata[7:0]` with `acc_rdata[15:8]` = 0. This is access 1 when little-endian and access 0 when big-endian. The other access carries bytes 1:0 as a full 16-bit value.
- R5: In the four-access mode, the fourth access is a pad. Its write data is discarded, and a read returns 0 on it. Any read on an 8-bit bus returns 0 in `acc_rdata[15:8]`.
- R6: With 16-bit data, `int_wdata[23:16]` is 0 whenever `int_wvalid` is 1.
- R7: `int_rreq` is 1 only while a read access is the first of its transaction, and `int_rdata` is sampled in that same cycle. Later accesses of that transaction return parts of the sampled word, even if `int_rdata` changes.
- R8: `int_wvalid` is a one-cycle pulse in the cycle after the last write access. `acc_rdata` updates in the cycle after each read access and otherwise keeps its value, including through write accesses.
- R9: When `cfg_bus16`, `cfg_data24` or `cfg_pad` changes, the partly gathered word is dropped. An access in the same cycle as the change counts as the first access under the new settings.
- R10: After a synchronous active-low reset, `int_wvalid`, `int_rreq`, `acc_rdata` and `int_wdata` are 0, and the next access is the first of a transaction.
- R11: After the last access of a transaction, the next access starts a new transaction with no idle cycle required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus16 | input | 1 | 1: 16-bit host bus, 0: 8-bit host bus |
| cfg_data24 | input | 1 | 1: 24-bit internal word, 0: 16-bit internal word |
| cfg_pad | input | 1 | 1: add pad access (8-bit bus, 24-bit data) |
| cfg_big_end | input | 1 | 1: most significant part moves first |
| acc_strobe | input | 1 | One host data access in this cycle |
| acc_write | input | 1 | 1: write access, 0: read access |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data, registered |
| int_wvalid | output | 1 | Packed word valid pulse |
| int_wdata | output | 24 | Packed internal word |
| int_rreq | output | 1 | Internal word fetch request |
| int_rdata | input | 24 | Internal word returned for a fetch |

## Verification
A change of bus width or data type can land in the same cycle as a host access. The counter reset and the first access of the new transaction must then resolve together. The bench provokes this in two ways. First, it switches the settings in the middle of a gathered word, between accesses. Second, it switches from an 8-bit to a 16-bit bus in the very cycle of a write strobe, after one byte has already been gathered. In both cases it judges the outcome from `int_wvalid` and `int_wdata`, which must show only data sent under the new settings, and must complete after exactly the access count that the new settings call for.

// File: rtl/hwp_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the host width packing engine.
// Assumes access index k counts from 0 within one transaction.
package hwp_pkg;

    typedef logic [1:0] hwp_idx_t;

    // Number of host accesses in one transaction.
    function automatic logic [2:0] acc_total(input logic wide, input logic d24, input logic pad);
        if (wide)
            return d24 ? 3'd2 : 3'd1;
        else if (!d24)
            return 3'd2;
        else
            return pad ? 3'd4 : 3'd3;
    endfunction

    // Word byte carried by access k on an 8-bit bus.
    function automatic hwp_idx_t byte_sel(input logic d24, input logic big, input hwp_idx_t k);
        hwp_idx_t top;
        top = d24 ? 2'd2 : 2'd1;
        return big ? hwp_idx_t'(top - k) : k;
    endfunction

    // True when access k on an 8-bit bus carries a real byte, not a pad.
    function automatic logic byte_live(input logic d24, input hwp_idx_t k);
        return d24 ? (k < 2'd3) : (k < 2'd2);
    endfunction

    // True when access k on a 16-bit bus carries bytes 1:0, not byte 2.
    function automatic logic full_seg(input logic d24, input logic big, input hwp_idx_t k);
        return !d24 || (k == (big ? 2'd1 : 2'd0));
    endfunction

endpackage

// File: rtl/hwp_seq.sv
`timescale 1ns/1ps
// Module: hwp_seq
// Tracks the access position inside the current transaction.
// It drops back to position 0 when the bus width, data type or pad
// setting differs from the value seen one cycle earlier.
// Assumes one access per strobe cycle.
module hwp_seq
    import hwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wide,
    input  logic     d24,
    input  logic     pad,
    input  logic     strobe,
    output hwp_idx_t idx,
    output logic     first,
    output logic     last
);
    hwp_idx_t   cnt_q;
    logic [2:0] shape_q;
    logic       changed;
    logic [2:0] total;

    // Effective position: a settings change restarts the transaction.
    always_comb begin
        changed = ({wide, d24, pad} != shape_q);
        idx     = changed ? 2'd0 : cnt_q;
        total   = acc_total(wide, d24, pad);
        first   = (idx == 2'd0);
        last    = ({1'b0, idx} == (total - 3'd1));
    end

    // Advance the position on each access and remember the settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shape_q <= '0;
        end else begin
            shape_q <= {wide, d24, pad};
            if (strobe)
                cnt_q <= last ? 2'd0 : hwp_idx_t'(idx + 2'd1);
            else
                cnt_q <= idx;
        end
    end
endmodule

// File: rtl/hwp_pack.sv
`timescale 1ns/1ps
// Module: hwp_pack
// Gathers host write data into one internal word and pulses the valid
// output in the cycle after the last access of a transaction.
// Assumes idx, first and last come from hwp_seq for the same cycle.
module hwp_pack
    import hwp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide,
    input  logic                d24,
    input  logic                big,
    input  logic                wr_en,
    input  hwp_idx_t            idx,
    input  logic                first,
    input  logic                last,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic                wvalid,
    output logic [3*BYTE_W-1:0] word
);
    localparam int HOST_W = 2 * BYTE_W;
    localparam int WORD_W = 3 * BYTE_W;

    logic [WORD_W-1:0] gath_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic              wvalid_q;

    // Place this access's data into the word gathered so far.
    always_comb begin
        merged = first ? '0 : gath_q;
        if (!wide) begin
            if (byte_live(d24, idx))
                merged[32'(byte_sel(d24, big, idx)) * BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
        end else if (full_seg(d24, big, idx)) begin
            merged[HOST_W-1:0] = wdata;
        end else begin
            merged[WORD_W-1:HOST_W] = wdata[BYTE_W-1:0];
        end
    end

    // Keep the partial word and publish it on the last access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gath_q   <= '0;
            word_q   <= '0;
            wvalid_q <= 1'b0;
        end else begin
            wvalid_q <= wr_en && last;
            if (wr_en)
                gath_q <= merged;
            if (wr_en && last)
                word_q <= merged;
        end
    end

    assign wvalid = wvalid_q;
    assign word   = word_q;
endmodule

// File: rtl/hwp_unpack.sv
`timescale 1ns/1ps
// Module: hwp_unpack
// Fetches one internal word on the first read access of a transaction,
// holds it, and returns one piece per access as registered read data.
// Assumes the internal side answers int_rdata in the request cycle.
module hwp_unpack
    import hwp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide,
    input  logic                d24,
    input  logic                big,
    input  logic                rd_en,
    input  hwp_idx_t            idx,
    input  logic                first,
    input  logic [3*BYTE_W-1:0] int_rdata,
    output logic                rreq,
    output logic [2*BYTE_W-1:0] rdata
);
    localparam int HOST_W = 2 * BYTE_W;
    localparam int WORD_W = 3 * BYTE_W;

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] src;
    logic [HOST_W-1:0] chunk;
    logic [HOST_W-1:0] rdata_q;

    // Pick the word source and the piece this access returns.
    always_comb begin
        rreq  = rd_en && first;
        src   = first ? int_rdata : hold_q;
        chunk = '0;
        if (!wide) begin
            if (byte_live(d24, idx))
                chunk[BYTE_W-1:0] = src[32'(byte_sel(d24, big, idx)) * BYTE_W +: BYTE_W];
        end else if (full_seg(d24, big, idx)) begin
            chunk = src[HOST_W-1:0];
        end else begin
            chunk[BYTE_W-1:0] = src[WORD_W-1:HOST_W];
        end
    end

    // Register the returned piece and hold the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (rd_en)
                rdata_q <= chunk;
            if (rreq)
                hold_q <= int_rdata;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/host_width_packer.sv
`timescale 1ns/1ps
// Module: host_width_packer
// Top of the host data width packing engine: converts between 8/16-bit
// host accesses and 16/24-bit internal words in both directions.
// Assumes a host never mixes reads and writes within one transaction.
module host_width_packer
    import hwp_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int HOST_W = 2 * BYTE_W,
    localparam int WORD_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus16,
    input  logic              cfg_data24,
    input  logic              cfg_pad,
    input  logic              cfg_big_end,
    input  logic              acc_strobe,
    input  logic              acc_write,
    input  logic [HOST_W-1:0] acc_wdata,
    output logic [HOST_W-1:0] acc_rdata,
    output logic              int_wvalid,
    output logic [WORD_W-1:0] int_wdata,
    output logic              int_rreq,
    input  logic [WORD_W-1:0] int_rdata
);
    hwp_idx_t idx;
    logic     first;
    logic     last;
    logic     wr_en;
    logic     rd_en;

    // Split the access strobe by direction.
    always_comb begin
        wr_en = acc_strobe && acc_write;
        rd_en = acc_strobe && !acc_write;
    end

    hwp_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wide   (cfg_bus16),
        .d24    (cfg_data24),
        .pad    (cfg_pad),
        .strobe (acc_strobe),
        .idx    (idx),
        .first  (first),
        .last   (last)
    );

    hwp_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wide   (cfg_bus16),
        .d24    (cfg_data24),
        .big    (cfg_big_end),
        .wr_en  (wr_en),
        .idx    (idx),
        .first  (first),
        .last   (last),
        .wdata  (acc_wdata),
        .wvalid (int_wvalid),
        .word   (int_wdata)
    );

    hwp_unpack #(.BYTE_W(BYTE_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (cfg_bus16),
        .d24       (cfg_data24),
        .big       (cfg_big_end),
        .rd_en     (rd_en),
        .idx       (idx),
        .first     (first),
        .int_rdata (int_rdata),
        .rreq      (int_rreq),
        .rdata     (acc_rdata)
    );
endmodule

// File: rtl/host_width_packer_chk.sv
`timescale 1ns/1ps
// Module: host_width_packer_chk
// Port-level temporal checks for host_width_packer, attached by bind.
module host_width_packer_chk #(
    parameter int BYTE_W = 8,
    localparam int HOST_W = 2 * BYTE_W,
    localparam int WORD_W = 3 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bus16,
    input logic              cfg_data24,
    input logic              acc_strobe,
    input logic              acc_write,
    input logic [HOST_W-1:0] acc_rdata,
    input logic              int_wvalid,
    input logic [WORD_W-1:0] int_wdata,
    input logic              int_rreq
);
    // R8
    wvalid_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_wvalid |-> $past(acc_strobe && acc_write));

    // R7
    rreq_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rreq |-> (acc_strobe && !acc_write));

    // R5
    narrow_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_strobe && !acc_write && !cfg_bus16) |=> (acc_rdata[HOST_W-1:BYTE_W] == '0));

    // R6
    short_word_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wvalid && !$past(cfg_data24)) |-> (int_wdata[WORD_W-1:HOST_W] == '0));

    // R1
    single_access_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_strobe && acc_write && cfg_bus16 && !cfg_data24) |=> int_wvalid);

    // R8
    rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_strobe && !acc_write) |=> $stable(acc_rdata));
endmodule

bind host_width_packer host_width_packer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bus16  (cfg_bus16),
    .cfg_data24 (cfg_data24),
    .acc_strobe (acc_strobe),
    .acc_write  (acc_write),
    .acc_rdata  (acc_rdata),
    .int_wvalid (int_wvalid),
    .int_wdata  (int_wdata),
    .int_rreq   (int_rreq)
);

// File: tb/host_width_packer_test.sv
`timescale 1ns/1ps
// Bench: sweeps every setting combination with write and read
// transactions and checks against arithmetically computed values.
module host_width_packer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_bus16, cfg_data24, cfg_pad, cfg_big_end;
    logic        acc_strobe, acc_write;
    logic [15:0] acc_wdata;
    logic [15:0] acc_rdata;
    logic        int_wvalid;
    logic [23:0] int_wdata;
    logic        int_rreq;
    logic [23:0] int_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    host_width_packer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_bus16(cfg_bus16), .cfg_data24(cfg_data24),
        .cfg_pad(cfg_pad), .cfg_big_end(cfg_big_end),
        .acc_strobe(acc_strobe), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .int_wvalid(int_wvalid), .int_wdata(int_wdata),
        .int_rreq(int_rreq), .int_rdata(int_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int n_acc(input bit w, input bit d, input bit p);
        if (w) return d ? 2 : 1;
        if (!d) return 2;
        return p ? 4 : 3;
    endfunction

    // Piece of word W that access k carries, per R2..R5.
    function automatic logic [15:0] piece(input bit w, input bit d, input bit b,
                                          input int k, input logic [23:0] W);
        int nb, sel;
        if (!w) begin
            nb = d ? 3 : 2;
            if (k >= nb) return 16'h0;
            sel = b ? (nb - 1 - k) : k;
            return 16'((W >> (8 * sel)) & 24'hFF);
        end
        if (!d) return W[15:0];
        if (k == (b ? 1 : 0)) return W[15:0];
        return {8'h00, W[23:16]};
    endfunction

    task automatic set_cfg(input bit w, input bit d, input bit p, input bit b);
        @(negedge clk);
        cfg_bus16 = w; cfg_data24 = d; cfg_pad = p; cfg_big_end = b;
    endtask

    task automatic do_acc(input bit wr, input logic [15:0] dat, output bit rq,
                          output bit wv, output logic [23:0] wd, output logic [15:0] rd);
        @(negedge clk);
        acc_strobe = 1'b1; acc_write = wr; acc_wdata = dat;
        #1 rq = int_rreq;
        @(negedge clk);
        acc_strobe = 1'b0;
        wv = int_wvalid; wd = int_wdata; rd = acc_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit rq, wv;
        logic [23:0] wd, W, mask;
        logic [15:0] rd, dat, last_rd;
        rst_n = 1'b0; acc_strobe = 1'b0; acc_write = 1'b0; acc_wdata = '0;
        int_rdata = '0;
        cfg_bus16 = 0; cfg_data24 = 0; cfg_pad = 0; cfg_big_end = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 wvalid", 32'(int_wvalid), 0);
        check("R10 rdata", 32'(acc_rdata), 0);
        check("R10 wdata", 32'(int_wdata), 0);
        check("R10 rreq", 32'(int_rreq), 0);
        rst_n = 1'b1;

        for (int c = 0; c < 16; c++) begin
            bit w, d, p, b;
            int n;
            w = c[0]; d = c[1]; p = c[2]; b = c[3];
            n = n_acc(w, d, p);
            set_cfg(w, d, p, b);
            for (int t = 0; t < 2; t++) begin
                W = 24'((32'h5A3C96 * (c + 1)) ^ (t * 32'h9E3779));
                mask = d ? 24'hFFFFFF : 24'h00FFFF;
                // read transaction: R7 fetch and hold, R4/R5 pieces
                int_rdata = W;
                for (int k = 0; k < n; k++) begin
                    do_acc(1'b0, 16'hFFFF, rq, wv, wd, rd);
                    check(k == 0 ? "R7 rreq first" : "R7 rreq later", 32'(rq), 32'(k == 0));
                    check(t == 1 && k == 0 ? "R11 read piece" :
                          (k == 3 ? "R5 pad read" : (w && d ? "R4 read piece" : "R7 read piece")),
                          32'(rd), 32'(piece(w, d, b, k, W)));
                    int_rdata = ~W;
                    last_rd = rd;
                end
                // write transaction: R1 count, R2/R3 order, R6 top byte
                W = W ^ 24'h0F0F0F;
                for (int k = 0; k < n; k++) begin
                    dat = piece(w, d, b, k, W);
                    if (!w) dat[15:8] = 8'h3C;
                    if (w && d && dat[15:8] == 8'h00 && k == (b ? 0 : 1)) dat[15:8] = 8'h5A;
                    if (k == 3) dat = 16'hA5A5;
                    do_acc(1'b1, dat, rq, wv, wd, rd);
                    if (k < n - 1) begin
                        check("R1 no early valid", 32'(wv), 0);
                    end else begin
                        check("R1 valid on last", 32'(wv), 1);
                        check(b ? "R3 packed word" : "R2 packed word", 32'(wd), 32'(W & mask));
                    end
                end
                @(negedge clk);
                check("R8 pulse width", 32'(int_wvalid), 0);
                check("R8 rdata held", 32'(acc_rdata), 32'(last_rd));
            end
        end

        // R9: change mid-word between accesses drops the partial word
        set_cfg(0, 1, 0, 0);
        do_acc(1'b1, 16'h0011, rq, wv, wd, rd);
        set_cfg(0, 0, 0, 0);
        do_acc(1'b1, 16'h0022, rq, wv, wd, rd);
        check("R9 restart count", 32'(wv), 0);
        do_acc(1'b1, 16'h0033, rq, wv, wd, rd);
        check("R9 new word valid", 32'(wv), 1);
        check("R9 new word data", 32'(wd), 32'h003322);

        // R9: change in the same cycle as a strobe
        do_acc(1'b1, 16'h0044, rq, wv, wd, rd);
        check("R9 partial", 32'(wv), 0);
        @(negedge clk);
        cfg_bus16 = 1'b1;
        acc_strobe = 1'b1; acc_write = 1'b1; acc_wdata = 16'hBEEF;
        @(negedge clk);
        acc_strobe = 1'b0;
        check("R9 same-cycle valid", 32'(int_wvalid), 1);
        check("R9 same-cycle data", 32'(int_wdata), 32'h00BEEF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule